// File: doc/BRIEF.md
# Nested Interrupt Priority Selector

This block delivers interrupts to a single processor core. Sixteen request inputs each carry a programmable priority, a mask bit, a trigger type (pulse-captured or level-followed) and a vector. A request is signalled on the interrupt output only when it outranks both the current task priority and every interrupt the core is already servicing. The core then runs an acknowledge cycle and receives the vector of the winning source, or a programmable spurious vector when nothing qualifies at that moment.

Interrupts that are in service are tracked one bit per source, so handlers can nest. A higher-priority arrival preempts the running handler. A lower one waits until the handlers above it have finished. Each end-of-interrupt write retires only the highest-priority entry that is in service. The next pending request is then considered again at once. All settings are loaded through a small register-write port.

Top module: `irq_nest_sel`

## Requirements
- R1: After reset the interrupt output and the acknowledge-valid output are low. Every source is masked, with priority 0 and edge type. The task priority is 0 and the spurious vector is 8'hFF.
- R2: A source is eligible when all of these hold: it is pending, it is unmasked, its priority is strictly greater than the task priority, and it is strictly greater than the highest in-service priority. Priority 0 never signals. `int_o` is high in the same cycle that any source is eligible.
- R3: A one-cycle `iack_i` pulse produces `ack_valid_o` high for exactly the following cycle. `ack_vec_o` then carries the vector of the eligible source with the highest priority. Among equal priorities the lowest source index wins.
- R4: If no source is eligible at the acknowledge, the spurious vector is returned. This covers four cases: a level source that dropped, a source masked after signalling, a task priority raised above the source, and no signal at all.
- R5: Acknowledging an eligible source sets its in-service bit. A spurious acknowledge sets no in-service bit and clears no pending bit.
- R6: A pending request whose priority is above the highest in-service priority raises `int_o` while lower interrupts are in service, and it is returned on the next acknowledge.
- R7: A pending request whose priority is not above the highest in-service priority keeps `int_o` low, even when it exceeds the task priority.
- R8: An `eoi_i` pulse clears only the in-service bit of highest priority (lowest index on ties). The remaining pending requests are then evaluated against the in-service entries that are left.
- R9: An `eoi_i` pulse while nothing is in service changes nothing.
- R10: An edge source becomes pending on a high cycle of its request input and stays pending until its own acknowledge; a request high in the acknowledge cycle keeps it pending. A level source is pending exactly while its input is high.
- R11: The write port decodes addresses as follows. Addresses 0..15 load a source word: bits [7:0] vector, [11:8] priority, [12] mask (1 = masked) and [13] type (1 = level). Address 16 loads the task priority from bits [3:0]. Address 17 loads the spurious vector from bits [7:0]. A write takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 16 | Request inputs, already synchronous |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_addr_i | input | 5 | Register write address |
| cfg_wdata_i | input | 14 | Register write data |
| iack_i | input | 1 | Interrupt acknowledge pulse |
| eoi_i | input | 1 | End-of-interrupt pulse |
| int_o | output | 1 | Interrupt request to the core |
| ack_valid_o | output | 1 | Acknowledge response valid |
| ack_vec_o | output | 8 | Returned vector |

## Verification
The assertions take `iack_i` and `eoi_i` to be single-cycle pulses. They also assume that an end-of-interrupt is never issued in the same cycle as an acknowledge, because the in-service checks reason about one change at a time. The stimulus drives each of these strobes for one cycle on its own, with idle cycles between them. It changes request inputs and registers only on the falling edge.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int PRIO_W = 4;
    localparam int VEC_W  = 8;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [VEC_W-1:0]  vec_t;

    // Source word; bit positions are part of the write-port decode.
    typedef struct packed {
        logic  level;
        logic  mask;
        prio_t prio;
        vec_t  vec;
    } src_cfg_t;

    localparam int   CFG_W    = $bits(src_cfg_t);
    localparam vec_t SPUR_RST = '1;

endpackage

// File: rtl/irq_nest_pick.sv
module irq_nest_pick #(
    parameter  int N  = 16,
    parameter  int W  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]        valid_i,
    input  logic [N-1:0][W-1:0] key_i,
    output logic                found_o,
    output logic [IW-1:0]       idx_o,
    output logic [W-1:0]        best_o
);

    // Strict compare keeps the lowest index among equal keys.
    always_comb begin
        found_o = 1'b0;
        idx_o   = '0;
        best_o  = '0;
        for (int i = 0; i < N; i++) begin
            if (valid_i[i] && (!found_o || key_i[i] > best_o)) begin
                found_o = 1'b1;
                idx_o   = IW'(i);
                best_o  = key_i[i];
            end
        end
    end

endmodule

// File: rtl/irq_nest_cfg.sv
module irq_nest_cfg
    import irq_nest_pkg::*;
#(
    parameter  int NUM_SRC = 16,
    localparam int IW      = $clog2(NUM_SRC),
    localparam int AW      = $clog2(NUM_SRC + 2)
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we_i,
    input  logic [AW-1:0]                addr_i,
    input  logic [CFG_W-1:0]             wdata_i,
    output src_cfg_t [NUM_SRC-1:0]       src_o,
    output prio_t                        tp_o,
    output vec_t                         spur_o
);

    typedef struct packed {
        src_cfg_t [NUM_SRC-1:0] src;
        prio_t                  tp;
        vec_t                   spur;
    } cfg_st_t;

    cfg_st_t q, d;

    always_comb begin
        d = q;
        if (we_i) begin
            if (int'(addr_i) < NUM_SRC) begin
                d.src[addr_i[IW-1:0]] = src_cfg_t'(wdata_i);
            end else if (int'(addr_i) == NUM_SRC) begin
                d.tp = wdata_i[PRIO_W-1:0];
            end else if (int'(addr_i) == NUM_SRC + 1) begin
                d.spur = wdata_i[VEC_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                q.src[i] <= '{level: 1'b0, mask: 1'b1, prio: '0, vec: '0};
            end
            q.tp   <= '0;
            q.spur <= SPUR_RST;
        end else begin
            q <= d;
        end
    end

    assign src_o  = q.src;
    assign tp_o   = q.tp;
    assign spur_o = q.spur;

    assert_tp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(tp_o) && $stable(spur_o));

endmodule

// File: rtl/irq_nest_sel.sv
module irq_nest_sel
    import irq_nest_pkg::*;
#(
    parameter  int NUM_SRC = 16,
    localparam int IW      = $clog2(NUM_SRC),
    localparam int AW      = $clog2(NUM_SRC + 2)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req_i,
    input  logic               cfg_we_i,
    input  logic [AW-1:0]      cfg_addr_i,
    input  logic [CFG_W-1:0]   cfg_wdata_i,
    input  logic               iack_i,
    input  logic               eoi_i,
    output logic               int_o,
    output logic               ack_valid_o,
    output logic [VEC_W-1:0]   ack_vec_o
);

    localparam logic [NUM_SRC-1:0] ONE = NUM_SRC'(1);

    typedef struct packed {
        logic [NUM_SRC-1:0] pend;
        logic [NUM_SRC-1:0] isr;
        logic               ack_valid;
        vec_t               ack_vec;
    } sel_st_t;

    sel_st_t q, d;

    src_cfg_t [NUM_SRC-1:0]          src_cfg;
    prio_t                           tp;
    vec_t                            spur;
    logic [NUM_SRC-1:0][PRIO_W-1:0]  prio_arr;
    logic [NUM_SRC-1:0]              level_m;
    logic [NUM_SRC-1:0]              cand;

    irq_nest_cfg #(.NUM_SRC(NUM_SRC)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (cfg_we_i),
        .addr_i  (cfg_addr_i),
        .wdata_i (cfg_wdata_i),
        .src_o   (src_cfg),
        .tp_o    (tp),
        .spur_o  (spur)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign prio_arr[g] = src_cfg[g].prio;
        assign level_m[g]  = src_cfg[g].level;
        assign cand[g]     = (src_cfg[g].level ? irq_req_i[g] : q.pend[g])
                             & ~src_cfg[g].mask;
    end

    logic          cand_found, isr_found;
    logic [IW-1:0] cand_idx, isr_idx;
    prio_t         cand_prio, isr_prio;

    irq_nest_pick #(.N(NUM_SRC), .W(PRIO_W)) u_pick_pend (
        .valid_i (cand),
        .key_i   (prio_arr),
        .found_o (cand_found),
        .idx_o   (cand_idx),
        .best_o  (cand_prio)
    );

    irq_nest_pick #(.N(NUM_SRC), .W(PRIO_W)) u_pick_isr (
        .valid_i (q.isr),
        .key_i   (prio_arr),
        .found_o (isr_found),
        .idx_o   (isr_idx),
        .best_o  (isr_prio)
    );

    prio_t              thr;
    logic               eligible;
    logic [NUM_SRC-1:0] sel_oh, retire_oh, clr_pend;

    always_comb begin
        thr       = (isr_prio > tp) ? isr_prio : tp;
        eligible  = cand_found && (cand_prio > thr);
        sel_oh    = eligible ? (ONE << cand_idx) : '0;
        retire_oh = (eoi_i && isr_found) ? (ONE << isr_idx) : '0;
        clr_pend  = iack_i ? (sel_oh & ~level_m) : '0;

        d           = q;
        d.ack_valid = iack_i;
        if (iack_i) begin
            d.ack_vec = eligible ? src_cfg[cand_idx].vec : spur;
        end
        d.pend = ((q.pend & ~clr_pend) | irq_req_i) & ~level_m;
        d.isr  = (q.isr & ~retire_oh) | (iack_i ? sel_oh : '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign int_o       = eligible;
    assign ack_valid_o = q.ack_valid;
    assign ack_vec_o   = q.ack_vec;

    assert_ack_resp_R3: assert property (@(posedge clk) disable iff (!rst_n)
        iack_i |=> ack_valid_o);

    assert_ack_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_i |=> !ack_valid_o);

    assert_spur_no_isr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_i && !int_o && !eoi_i) |=> $stable(q.isr));

    assert_isr_no_grow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !iack_i |=> ($countones(q.isr) <= $countones($past(q.isr))));

    assert_eoi_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !iack_i && q.isr != '0) |=>
        ($countones(q.isr) + 1 == $countones($past(q.isr))));

    assert_eoi_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_i && !iack_i && q.isr == '0) |=> (q.isr == '0));

endmodule

// File: tb/irq_nest_sel_bench.sv
module irq_nest_sel_bench;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req = '0;
    logic        we = 1'b0;
    logic [4:0]  addr = '0;
    logic [13:0] wdata = '0;
    logic        iack = 1'b0;
    logic        eoi = 1'b0;
    logic        intr;
    logic        ack_valid;
    logic [7:0]  ack_vec;

    int total = 0;
    int bad   = 0;

    always #(CLK_P / 2) clk = ~clk;

    irq_nest_sel u_irq_nest_sel (
        .clk         (clk),
        .rst_n       (rst_n),
        .irq_req_i   (req),
        .cfg_we_i    (we),
        .cfg_addr_i  (addr),
        .cfg_wdata_i (wdata),
        .iack_i      (iack),
        .eoi_i       (eoi),
        .int_o       (intr),
        .ack_valid_o (ack_valid),
        .ack_vec_o   (ack_vec)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_int(input string tag, input logic exp);
        #1;
        chk(tag, {31'b0, intr}, {31'b0, exp});
    endtask

    task automatic wr(input int a, input logic [13:0] v);
        @(negedge clk);
        we = 1'b1; addr = 5'(a); wdata = v;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic set_src(input int idx, input logic lvl, input logic msk,
                           input logic [3:0] pr, input logic [7:0] vec);
        wr(idx, {lvl, msk, pr, vec});
    endtask

    task automatic pulse(input logic [15:0] m);
        @(negedge clk);
        req = req | m;
        @(negedge clk);
        req = req & ~m;
    endtask

    task automatic ack_chk(input string tag, input logic [7:0] exp);
        @(negedge clk);
        iack = 1'b1;
        @(negedge clk);
        iack = 1'b0;
        chk({tag, " valid"}, {31'b0, ack_valid}, 32'd1);
        chk({tag, " vector"}, {24'b0, ack_vec}, {24'b0, exp});
    endtask

    task automatic do_eoi();
        @(negedge clk);
        eoi = 1'b1;
        @(negedge clk);
        eoi = 1'b0;
    endtask

    task automatic t_reset();
        chk_int("R1 int after reset", 1'b0);
        chk("R1 ack_valid after reset", {31'b0, ack_valid}, 32'd0);
        ack_chk("R4 R1 ack with nothing signalled", 8'hFF);
        @(negedge clk);
        chk("R3 valid lasts one cycle", {31'b0, ack_valid}, 32'd0);
    endtask

    task automatic t_prio_zero();
        set_src(0, 1'b0, 1'b0, 4'd0, 8'h01);
        pulse(16'h0001);
        chk_int("R2 priority zero never signals", 1'b0);
        ack_chk("R4 priority zero ack", 8'hFF);
        set_src(0, 1'b0, 1'b1, 4'd0, 8'h01);
    endtask

    task automatic t_basic();
        set_src(3, 1'b0, 1'b0, 4'd5, 8'h33);
        chk_int("R2 idle before request", 1'b0);
        pulse(16'h0008);
        chk_int("R2 edge source signals", 1'b1);
        ack_chk("R3 basic ack", 8'h33);
        chk_int("R10 edge pending cleared by ack", 1'b0);
        pulse(16'h0008);
        chk_int("R7 same priority held while in service", 1'b0);
        do_eoi();
        chk_int("R8 re-evaluated after eoi", 1'b1);
        ack_chk("R3 second ack", 8'h33);
        do_eoi();
        chk_int("R10 nothing left pending", 1'b0);
    endtask

    task automatic t_tie();
        set_src(2, 1'b0, 1'b0, 4'd6, 8'h22);
        set_src(7, 1'b0, 1'b0, 4'd6, 8'h77);
        pulse(16'h0084);
        chk_int("R2 tie signals", 1'b1);
        ack_chk("R3 tie to lower index", 8'h22);
        chk_int("R7 equal priority held", 1'b0);
        do_eoi();
        chk_int("R8 tie partner after eoi", 1'b1);
        ack_chk("R3 tie partner", 8'h77);
        do_eoi();
        chk_int("R8 tie drained", 1'b0);
    endtask

    task automatic t_nest();
        set_src(4, 1'b0, 1'b0, 4'd5, 8'h44);
        set_src(9, 1'b0, 1'b0, 4'd9, 8'h99);
        set_src(1, 1'b0, 1'b0, 4'd4, 8'h11);
        pulse(16'h0010);
        ack_chk("R5 first level nest", 8'h44);
        pulse(16'h0200);
        chk_int("R6 higher priority preempts", 1'b1);
        ack_chk("R6 preempting vector", 8'h99);
        pulse(16'h0002);
        chk_int("R7 lower held above task priority", 1'b0);
        do_eoi();
        chk_int("R8 only highest retired", 1'b0);
        do_eoi();
        chk_int("R8 lower released after second eoi", 1'b1);
        ack_chk("R8 released vector", 8'h11);
        do_eoi();
        chk_int("R8 all drained", 1'b0);
        pulse(16'h0200);
        do_eoi();
        chk_int("R9 empty eoi keeps pending", 1'b1);
        ack_chk("R9 vector after empty eoi", 8'h99);
        do_eoi();
    endtask

    task automatic t_level();
        set_src(5, 1'b1, 1'b0, 4'd3, 8'h55);
        @(negedge clk); req[5] = 1'b1;
        chk_int("R10 level high signals", 1'b1);
        @(negedge clk); req[5] = 1'b0;
        chk_int("R10 level low drops", 1'b0);
        ack_chk("R4 level dropped before ack", 8'hFF);
        @(negedge clk); req[5] = 1'b1;
        ack_chk("R3 level ack", 8'h55);
        chk_int("R7 level held while in service", 1'b0);
        do_eoi();
        chk_int("R10 level stays pending", 1'b1);
        ack_chk("R10 level second ack", 8'h55);
        @(negedge clk); req[5] = 1'b0;
        do_eoi();
        chk_int("R10 level drained", 1'b0);
    endtask

    task automatic t_mask();
        set_src(6, 1'b0, 1'b0, 4'd7, 8'h66);
        pulse(16'h0040);
        chk_int("R2 source six signals", 1'b1);
        set_src(6, 1'b0, 1'b1, 4'd7, 8'h66);
        chk_int("R2 masked drops int", 1'b0);
        ack_chk("R4 masked before ack", 8'hFF);
        set_src(6, 1'b0, 1'b0, 4'd7, 8'h66);
        chk_int("R5 spurious ack kept pending", 1'b1);
        ack_chk("R5 unmasked vector", 8'h66);
        do_eoi();
    endtask

    task automatic t_task_prio();
        set_src(8, 1'b0, 1'b0, 4'd4, 8'h88);
        wr(16, 14'd4);
        pulse(16'h0100);
        chk_int("R2 equal to task priority blocked", 1'b0);
        wr(16, 14'd3);
        chk_int("R2 above task priority", 1'b1);
        wr(16, 14'd6);
        chk_int("R2 raised task priority", 1'b0);
        ack_chk("R4 task priority raised", 8'hFF);
        wr(16, 14'd0);
        ack_chk("R11 task priority cleared", 8'h88);
        do_eoi();
    endtask

    task automatic t_spur_isr();
        wr(17, 14'h5A);
        ack_chk("R11 programmed spurious vector", 8'h5A);
        set_src(10, 1'b0, 1'b0, 4'd1, 8'hAA);
        pulse(16'h0400);
        chk_int("R5 spurious ack left in-service empty", 1'b1);
        ack_chk("R5 lowest priority vector", 8'hAA);
        do_eoi();
        chk_int("R9 final idle", 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prio_zero();
        t_basic();
        t_tie();
        t_nest();
        t_level();
        t_mask();
        t_task_prio();
        t_spur_isr();
        repeat (2) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule